// File: doc/BRIEF.md
# Four-Channel Serial Converter Scan Controller

This block is the host-side master for a four-wire serial link to a 12-bit sampling converter with four analog inputs. It divides the system clock down to a serial clock and drives chip select. In each 16-clock frame it sends a control byte that names the input for the next conversion, and it collects the result of the conversion that is running now. Software or a sequencer sets which inputs are scanned with a four-bit enable mask. Results leave the block as a 12-bit code with a 2-bit channel tag over a valid/ready handshake.

The converter applies an address one frame after it is written. The controller keeps track of this one-frame lag, so every result carries the channel that was really converted. The first conversion after power-up always comes from input 1, whatever the mask says. A single-shot request runs one frame. Continuous mode keeps chip select low and runs frames back to back for as long as the consumer keeps up. When the consumer stalls, the controller ends the burst at a frame boundary and waits.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `cs_n` is 1, `sclk` is 1, `mosi` is 0 and `res_valid` is 0.
- R2: `sclk` is 1 whenever `cs_n` is 1, and `cs_n` falls only while `sclk` is 1. Each half period of `sclk` lasts HALF_DIV system clocks. Each time `cs_n` is low, `sclk` rises a whole multiple of 16 times.
- R3: The control byte goes out on `mosi` MSB first. It changes after falling `sclk` edges and is sampled on rising edges 1 to 8 of a frame. Bits 4:3 carry the channel code (00 input 1, 01 input 2, 10 input 3, 11 input 4). Every other bit is 0.
- R4: `miso` is sampled on rising `sclk` edges. The first four bits of each frame are dropped. The last twelve form `res_code`, MSB first, as straight binary (0x000 is the lowest input, 0xFFF the highest).
- R5: `res_chan` holds the channel code sent in the frame before the one that produced the result. The first result after reset is tagged 0 (input 1).
- R6: The address sent in a frame is the next enabled channel above the last address sent, searching upward and wrapping from 3 back to 0. Disabled channels are skipped. The mask is read when the frame starts.
- R7: While `en_mask` is 0, no frame starts and `cs_n` stays 1.
- R8: A `start` pulse while the link is idle and `continuous` is 0 runs exactly one frame. A `start` pulse while a frame is running has no effect.
- R9: While `continuous` is 1, frames follow each other under one low period of `cs_n`. When the burst ends, `cs_n` rises HALF_DIV system clocks after the last rising `sclk` edge.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_code` and `res_chan` hold. No frame starts or continues while a result is waiting, so no result is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_mask | input | 4 | Channel enable, bit n enables input n+1 |
| continuous | input | 1 | 1 keeps scanning back to back |
| start | input | 1 | One-cycle pulse that requests a single frame |
| sclk | output | 1 | Serial clock to the converter, idle high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Control byte to the converter |
| miso | input | 1 | Result bits from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_chan | output | 2 | Channel the result was converted from |
| res_code | output | 12 | 12-bit conversion result |

## Verification
The bench builds the controller with HALF_DIV = 3, so a serial period is six system clocks and a frame is 96. This puts dozens of frames within reach: runs long enough to wrap the round-robin several times under full, sparse and single-channel masks, and to pass through the one-frame address lag across burst boundaries. The short frame also lets a randomly withheld ready stall and restart bursts many times. It covers the 0x000 and 0xFFF codes from the converter model.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int NUM_CH    = 4;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int CODE_W    = 12;
    localparam int WORD_W    = 16;
    localparam int CTRL_W    = 8;
    localparam int ADDR_LSB  = 3;
    localparam int BIT_CNT_W = $clog2(WORD_W);

    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [NUM_CH-1:0] mask_t;

    typedef struct packed {
        chan_t chan;
        code_t code;
    } result_t;

    typedef enum logic [1:0] {
        LNK_IDLE,
        LNK_LEAD,
        LNK_SHIFT,
        LNK_GAP
    } link_st_e;

    // Control byte: channel code at ADDR_LSB, all other bits zero.
    function automatic logic [CTRL_W-1:0] ctrl_byte(chan_t ch);
        logic [CTRL_W-1:0] b;
        b = '0;
        b[ADDR_LSB +: CH_W] = ch;
        return b;
    endfunction

    // Next enabled channel strictly above cur, wrapping; cur itself last.
    function automatic chan_t next_enabled(chan_t cur, mask_t mask);
        chan_t r;
        chan_t cand;
        r = cur;
        for (int i = NUM_CH; i >= 1; i--) begin
            cand = chan_t'((int'(cur) + i) % NUM_CH);
            if (mask[cand]) r = cand;
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == CNT_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick
    import adc_scan_pkg::*;
(
    input  chan_t             last_sent,
    input  mask_t             mask,
    output chan_t             next_ch,
    output logic [CTRL_W-1:0] next_ctrl
);
    always_comb begin
        next_ch   = next_enabled(last_sent, mask);
        next_ctrl = ctrl_byte(next_ch);
    end
endmodule

// File: rtl/adc_result_slot.sv
module adc_result_slot
    import adc_scan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  result_t load_data,
    input  logic    ready,
    output logic    valid,
    output result_t data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int HALF_DIV = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] en_mask,
    input  logic              continuous,
    input  logic              start,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [CH_W-1:0]   res_chan,
    output logic [CODE_W-1:0] res_code
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(WORD_W - 1);

    link_st_e              st;
    logic                  tick;
    logic                  sclk_r, cs_n_r, mosi_r;
    logic [CTRL_W-1:0]     ctrl_sr;
    logic [CODE_W-2:0]     rx_sr;
    logic [BIT_CNT_W-1:0]  bcnt;
    chan_t                 sent_ch, conv_ch, nxt_ch;
    logic [CTRL_W-1:0]     nxt_ctrl;
    logic                  start_pend;
    logic                  any_en, may_run, load;
    result_t               load_data, slot_data;

    adc_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    adc_chan_pick u_pick (
        .last_sent (sent_ch),
        .mask      (en_mask),
        .next_ch   (nxt_ch),
        .next_ctrl (nxt_ctrl)
    );

    assign any_en  = |en_mask;
    assign may_run = any_en && !res_valid;
    assign load    = tick && (st == LNK_SHIFT) && !sclk_r && (bcnt == LAST_BIT);

    always_comb begin
        load_data.chan = conv_ch;
        load_data.code = {rx_sr, miso};
    end

    adc_result_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .ready     (res_ready),
        .valid     (res_valid),
        .data      (slot_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= LNK_IDLE;
            sclk_r     <= 1'b1;
            cs_n_r     <= 1'b1;
            mosi_r     <= 1'b0;
            ctrl_sr    <= '0;
            rx_sr      <= '0;
            bcnt       <= '0;
            sent_ch    <= '0;
            conv_ch    <= '0;
            start_pend <= 1'b0;
        end else begin
            if (st == LNK_IDLE && start) start_pend <= 1'b1;
            if (tick) begin
                case (st)
                    LNK_IDLE: begin
                        if (may_run && (continuous || start_pend)) begin
                            cs_n_r     <= 1'b0;
                            ctrl_sr    <= nxt_ctrl;
                            conv_ch    <= sent_ch;
                            sent_ch    <= nxt_ch;
                            start_pend <= 1'b0;
                            st         <= LNK_LEAD;
                        end
                    end
                    LNK_LEAD: begin
                        sclk_r  <= 1'b0;
                        mosi_r  <= ctrl_sr[CTRL_W-1];
                        ctrl_sr <= {ctrl_sr[CTRL_W-2:0], 1'b0};
                        st      <= LNK_SHIFT;
                    end
                    LNK_SHIFT: begin
                        if (sclk_r) begin
                            sclk_r  <= 1'b0;
                            mosi_r  <= ctrl_sr[CTRL_W-1];
                            ctrl_sr <= {ctrl_sr[CTRL_W-2:0], 1'b0};
                        end else begin
                            sclk_r <= 1'b1;
                            rx_sr  <= {rx_sr[CODE_W-3:0], miso};
                            bcnt   <= bcnt + 1'b1;
                            if (bcnt == LAST_BIT) st <= LNK_GAP;
                        end
                    end
                    LNK_GAP: begin
                        if (may_run && continuous) begin
                            sclk_r  <= 1'b0;
                            mosi_r  <= nxt_ctrl[CTRL_W-1];
                            ctrl_sr <= {nxt_ctrl[CTRL_W-2:0], 1'b0};
                            conv_ch <= sent_ch;
                            sent_ch <= nxt_ch;
                            st      <= LNK_SHIFT;
                        end else begin
                            cs_n_r <= 1'b1;
                            mosi_r <= 1'b0;
                            st     <= LNK_IDLE;
                        end
                    end
                    default: st <= LNK_IDLE;
                endcase
            end
        end
    end

    assign sclk     = sclk_r;
    assign cs_n     = cs_n_r;
    assign mosi     = mosi_r;
    assign res_chan = slot_data.chan;
    assign res_code = slot_data.code;
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  en_mask,
    input logic        sclk,
    input logic        cs_n,
    input logic        mosi,
    input logic        res_valid,
    input logic        res_ready,
    input logic [1:0]  res_chan,
    input logic [11:0] res_code
);
    logic       sclk_q;
    logic [3:0] rcnt;
    logic       hi_bit;
    logic [1:0] sent_q, conv_q;
    logic       rise;

    assign rise = sclk && !sclk_q && !cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b1;
            rcnt   <= '0;
            hi_bit <= 1'b0;
            sent_q <= '0;
            conv_q <= '0;
        end else begin
            sclk_q <= sclk;
            if (cs_n) rcnt <= '0;
            else if (rise) begin
                rcnt <= rcnt + 1'b1;
                if (rcnt == 4'd3) hi_bit <= mosi;
                if (rcnt == 4'd4) sent_q <= {hi_bit, mosi};
                if (rcnt == 4'd0) conv_q <= sent_q;
            end
        end
    end

    // R2: serial clock idles high outside a frame
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R2: select falls with the serial clock high
    p_cs_fall_sclk_high_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> sclk);

    // R2: whole 16-edge frames under each select
    p_whole_frames_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (rcnt == 4'd0));

    // R3: don't-care control bits are driven low
    p_dontcare_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rise && rcnt < 4'd8 && rcnt != 4'd3 && rcnt != 4'd4) |-> !mosi);

    // R5: tag follows the address sent one frame earlier
    p_tag_pipeline_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> (res_chan == conv_q));

    // R7: no frame with an empty mask
    p_zero_mask_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> ($past(en_mask) != 4'd0));

    // R10: a waiting result holds
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_code) && $stable(res_chan)));

    // R10: no burst begins while a result waits
    p_no_start_full_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !$past(res_valid));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk u_chk (.*);

// File: tb/tb_adc_scan_ctrl.sv
`timescale 1ns/1ps
module tb_adc_scan_ctrl;
    localparam int  H    = 3;
    localparam time TCLK = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  en_mask = 4'd0;
    logic        continuous = 1'b0;
    logic        start = 1'b0;
    wire         sclk, cs_n, mosi;
    logic        miso = 1'b0;
    logic        res_ready = 1'b0;
    logic        res_valid;
    logic [1:0]  res_chan;
    logic [11:0] res_code;

    always #4 clk = ~clk;

    adc_scan_ctrl #(.HALF_DIV(H)) dut (
        .clk(clk), .rst(rst), .en_mask(en_mask), .continuous(continuous),
        .start(start), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .res_valid(res_valid), .res_ready(res_ready), .res_chan(res_chan),
        .res_code(res_code)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] next_en(logic [1:0] cur, logic [3:0] m);
        logic [1:0] c;
        for (int i = 1; i <= 4; i++) begin
            c = cur + 2'(i);
            if (m[c]) return c;
        end
        return cur;
    endfunction

    // converter model
    bit          run = 1'b0;
    int          dfall = 0, drise = 0, k = 0;
    int          frames = 0, cs_falls = 0, seq = 0;
    logic [15:0] dword;
    logic [11:0] cd;
    logic [7:0]  cap = 8'd0;
    logic [1:0]  dev_addr = 2'd0, pred_last = 2'd0, pred;
    logic [13:0] exp_q[$];
    time         last_rise = 0;
    bit          rise_seen = 1'b0;

    always @(negedge sclk) if (run && !cs_n) begin
        if (dfall == 0) begin
            seq++;
            if (seq % 7 == 3)      cd = 12'hFFF;
            else if (seq % 7 == 5) cd = 12'h000;
            else                   cd = 12'($urandom);
            dword = {4'b0000, cd};
            exp_q.push_back({dev_addr, cd});
        end
        miso <= dword[15-dfall];
        dfall = (dfall + 1) % 16;
    end

    always @(posedge sclk) if (run && !cs_n) begin
        k = drise + 1;
        if (rise_seen) chk(int'($time - last_rise) == 2*H*TCLK, "R2 serial period",
                           int'($time - last_rise), 2*H*TCLK);
        last_rise = $time;
        rise_seen = 1'b1;
        if (k <= 8) begin
            cap[8-k] = mosi;
            if (k != 4 && k != 5) chk(mosi == 1'b0, "R3 dont-care bit zero", mosi, 0);
        end
        if (k == 5) begin
            pred = next_en(pred_last, en_mask);
            chk(cap[4:3] == pred, "R6 round-robin address", cap[4:3], pred);
            pred_last = pred;
        end
        if (k == 16) begin
            dev_addr = cap[4:3];
            frames++;
        end
        drise = k % 16;
    end

    always @(negedge cs_n) if (run) begin
        cs_falls++;
        chk(sclk === 1'b1, "R2 sclk high at select fall", sclk, 1);
    end

    always @(posedge cs_n) if (run) begin
        chk(drise == 0 && dfall == 0, "R2 whole frames", drise, 0);
        chk(int'($time - last_rise) == H*TCLK, "R9 select release delay",
            int'($time - last_rise), H*TCLK);
        dfall = 0;
        drise = 0;
        rise_seen = 1'b0;
    end

    // result consumer and scoreboard
    int          rdy_mode = 1;
    int          results = 0;
    logic [1:0]  last_chan = 2'd0;
    logic [13:0] e;

    always @(negedge clk) begin
        bit r;
        case (rdy_mode)
            0:       r = 1'b0;
            1:       r = 1'b1;
            default: r = ($urandom % 4) != 0;
        endcase
        if (run && res_valid && r) begin
            results++;
            last_chan = res_chan;
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected result", res_code, 0);
            else begin
                e = exp_q.pop_front();
                chk(res_chan == e[13:12], "R5 channel tag", res_chan, e[13:12]);
                chk(res_code == e[11:0], "R4 result code", res_code, e[11:0]);
            end
        end
        res_ready = r;
    end

    task automatic settle();
        repeat (10*H) @(negedge clk);
        while (!(cs_n === 1'b1 && res_valid === 1'b0)) @(negedge clk);
        repeat (2*H) @(negedge clk);
    endtask

    task automatic scan_run(input logic [3:0] m, input int nfr, input int mode);
        int f0;
        en_mask  = m;
        rdy_mode = mode;
        f0 = frames;
        continuous = 1'b1;
        while (frames < f0 + nfr) @(negedge clk);
        continuous = 1'b0;
        settle();
        rdy_mode = 1;
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R10 no result lost", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int f0, c0;
        logic [11:0] snap_code;
        logic [1:0]  snap_chan;
        void'($urandom(32'd5150));
        repeat (5) @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
        chk(sclk == 1'b1, "R1 reset sclk", sclk, 1);
        chk(mosi == 1'b0, "R1 reset mosi", mosi, 0);
        chk(res_valid == 1'b0, "R1 reset res_valid", res_valid, 0);
        rst = 1'b0;
        run = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b1 && res_valid == 1'b0, "R1 state after reset", cs_n, 1);

        // R7: empty mask never starts a frame
        en_mask = 4'd0;
        continuous = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        chk(cs_falls == 0, "R7 empty mask no frame", cs_falls, 0);
        chk(cs_n == 1'b1, "R7 select stays high", cs_n, 1);
        continuous = 1'b0;
        repeat (4) @(negedge clk);

        // R8: single shot; second start during the frame is ignored
        en_mask = 4'hF;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk(cs_n == 1'b0, "R8 frame running", cs_n, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        settle();
        repeat (200) @(negedge clk);
        chk(frames == 1, "R8 exactly one frame", frames, 1);
        chk(results == 1, "R8 exactly one result", results, 1);
        chk(last_chan == 2'd0, "R5 first result from input 1", last_chan, 0);

        // R9: continuous full scan under one select
        c0 = cs_falls;
        scan_run(4'hF, 10, 1);
        chk(cs_falls == c0 + 1, "R9 back-to-back under one select", cs_falls, c0 + 1);

        // R6: directed sparse and single-channel masks
        scan_run(4'b0001, 4, 1);
        scan_run(4'b1000, 4, 1);
        scan_run(4'b0101, 6, 2);

        // R10: stalled consumer
        en_mask  = 4'hF;
        rdy_mode = 0;
        f0 = frames;
        continuous = 1'b1;
        repeat (300) @(negedge clk);
        snap_code = res_code;
        snap_chan = res_chan;
        repeat (1500) @(negedge clk);
        chk(frames == f0 + 1, "R10 stall after one frame", frames, f0 + 1);
        chk(res_valid == 1'b1, "R10 result still waiting", res_valid, 1);
        chk(res_code == snap_code && res_chan == snap_chan, "R10 held result stable",
            res_code, snap_code);
        rdy_mode = 1;
        repeat (400) @(negedge clk);
        continuous = 1'b0;
        settle();
        chk(exp_q.size() == 0, "R10 drained after stall", exp_q.size(), 0);

        // R6/R4: random masks with random ready
        for (int it = 0; it < 6; it++) begin
            logic [3:0] m;
            m = 4'($urandom);
            if (m == 4'd0) m = 4'b0110;
            scan_run(m, 7, 2);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule